// File: doc/BRIEF.md
# USB OUT Endpoint Receive Bank Manager

This block manages the receive buffers of one USB OUT endpoint. The endpoint has either one bank or two banks. For each data packet that the packet engine reports as received, the block decides at once whether to answer ACK or NAK. It accepts the packet only when the bank it would fill is free. When it accepts a packet, it stores the packet's byte count for that bank, marks the bank as owned by software and raises a received-data flag.

Software handles the two flags separately, each with its own write-one-to-clear bit. Clearing the received-data flag only acknowledges the event. Releasing the bank hands the buffer back to the hardware. With two banks, a release also moves the software-side pointer to the other bank, and the banks are filled and released in ping-pong order. An interrupt line is driven while the received-data flag is set and its enable is one.

Top module: `usb_out_bank_mgr`

## Requirements
- R1: After reset, rx_flag, bank_busy and irq are 0, bank_sel is 0, and both banks are free.
- R2: An accepted packet sets rx_flag in the next cycle. It also sets the ownership flag of the bank it filled in the same cycle, and bank_busy shows that flag whenever bank_sel points at that bank.
- R3: irq is 1 exactly when rx_flag is 1 and the enable is 1. The enable is written through sw_ie_wr with the value on sw_ie_val, and it resets to 0.
- R4: A write with sw_clr_rx=1 clears rx_flag and changes neither bank_busy nor bank_sel.
- R5: A write with sw_clr_busy=1, made while the bank selected by bank_sel is owned, frees that bank. With NUM_BANKS=2 it also toggles bank_sel.
- R6: With NUM_BANKS=1, a packet that arrives while the bank is owned gets nak=1 and ack=0. After the bank is released, the next packet gets ack=1.
- R7: With NUM_BANKS=2, a packet gets ack whenever the fill bank is free. Packets fill bank 0, then bank 1, then bank 0, and so on. A packet gets nak only when both banks are owned.
- R8: rd_count returns, without delay, the rx_count value stored with the last packet accepted into bank rd_bank. It returns 0 if no packet has been accepted into that bank since reset.
- R9: A write with both clear bits at 0 changes no flag. A release made while the selected bank is free changes nothing.
- R10: If a packet is accepted in the same cycle as a write that clears rx_flag, rx_flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Pulse: a packet has been received and asks for a handshake |
| rx_count | input | CNT_W | Byte count of the received packet |
| ack | output | 1 | Packet accepted (same cycle as rx_valid) |
| nak | output | 1 | Packet refused (same cycle as rx_valid) |
| sw_wr | input | 1 | Software write strobe for the clear bits |
| sw_clr_rx | input | 1 | Write one to clear rx_flag |
| sw_clr_busy | input | 1 | Write one to release the selected bank |
| sw_ie_wr | input | 1 | Write strobe for the interrupt enable |
| sw_ie_val | input | 1 | New interrupt enable value |
| rd_bank | input | 1 | Bank whose byte count is read |
| rd_count | output | CNT_W | Stored byte count of bank rd_bank |
| bank_sel | output | 1 | Bank currently selected for software |
| rx_flag | output | 1 | Received-data flag |
| bank_busy | output | 1 | Ownership flag of the selected bank |
| irq | output | 1 | Interrupt line |

## Verification
The assertions check on every cycle that ack and nak are never both high and never appear without rx_valid. They also check that an acceptance always leaves rx_flag set, even against a clear in the same cycle. Further checks confirm that clearing rx_flag leaves bank_sel alone, that a dual-bank release toggles bank_sel, and that zero writes disturb no flag. The bench scenarios show the full ACK/NAK sequence in the one-bank and two-bank variants, the ping-pong fill order, the stored byte counts, and the interaction of random clears, releases and enable writes against a reference model.

// File: rtl/usb_out_bank_mgr.sv
module usb_out_bank_mgr #(
  parameter int NUM_BANKS = 2,
  parameter int CNT_W     = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [CNT_W-1:0] rx_count,
  output logic             ack,
  output logic             nak,
  input  logic             sw_wr,
  input  logic             sw_clr_rx,
  input  logic             sw_clr_busy,
  input  logic             sw_ie_wr,
  input  logic             sw_ie_val,
  input  logic             rd_bank,
  output logic [CNT_W-1:0] rd_count,
  output logic             bank_sel,
  output logic             rx_flag,
  output logic             bank_busy,
  output logic             irq
);
  localparam logic DUAL = (NUM_BANKS > 1);

  logic [1:0]       busy;
  logic             wr_ptr, sw_ptr, flag, ie;
  logic [CNT_W-1:0] cnt [2];

  wire take = rx_valid & ~busy[wr_ptr];
  wire rel  = sw_wr & sw_clr_busy & busy[sw_ptr];

  assign ack       = take;
  assign nak       = rx_valid & busy[wr_ptr];
  assign rd_count  = cnt[rd_bank];
  assign bank_sel  = sw_ptr;
  assign rx_flag   = flag;
  assign bank_busy = busy[sw_ptr];
  assign irq       = flag & ie;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= '0;
      wr_ptr <= 1'b0;
      sw_ptr <= 1'b0;
      flag   <= 1'b0;
      ie     <= 1'b0;
      for (int i = 0; i < 2; i++) cnt[i] <= '0;
    end else begin
      if (take) begin
        busy[wr_ptr] <= 1'b1;
        cnt[wr_ptr]  <= rx_count;
        if (DUAL) wr_ptr <= ~wr_ptr;
      end
      if (rel) begin
        busy[sw_ptr] <= 1'b0;
        if (DUAL) sw_ptr <= ~sw_ptr;
      end
      if (take) flag <= 1'b1;
      else if (sw_wr && sw_clr_rx) flag <= 1'b0;
      if (sw_ie_wr) ie <= sw_ie_val;
    end
  end

  p_resp_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ack, nak}) && ((ack || nak) -> rx_valid));
  p_flag_on_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> rx_flag);
  p_irq_needs_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> rx_flag);
  p_clr_keeps_ptr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && sw_clr_rx && !sw_clr_busy) |=> $stable(bank_sel));
  p_release_toggles_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (DUAL && sw_wr && sw_clr_busy && bank_busy) |=> (bank_sel != $past(bank_sel)));
  p_zero_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && !sw_clr_rx && !sw_clr_busy && !rx_valid) |=> ($stable(rx_flag) && $stable(bank_busy)));
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && sw_wr && sw_clr_rx) |=> rx_flag);
endmodule

// File: tb/usb_out_bank_mgr_bench.sv
`timescale 1ns/1ps
module usb_out_bank_mgr_bench;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic rv = 0, wr = 0, crx = 0, cbz = 0, iew = 0, iev = 0, rb = 0;
  logic [10:0] rc = '0;
  logic ack_o [2], nak_o [2], sel_o [2], flg_o [2], bsy_o [2], irq_o [2];
  logic [10:0] rdc [2];
  int checks = 0, errors = 0;
  bit done = 0;

  usb_out_bank_mgr #(.NUM_BANKS(2), .CNT_W(11)) u_usb_out_bank_mgr (
    .clk(clk), .rst_n(rst_n), .rx_valid(rv), .rx_count(rc), .ack(ack_o[0]), .nak(nak_o[0]),
    .sw_wr(wr), .sw_clr_rx(crx), .sw_clr_busy(cbz), .sw_ie_wr(iew), .sw_ie_val(iev),
    .rd_bank(rb), .rd_count(rdc[0]), .bank_sel(sel_o[0]), .rx_flag(flg_o[0]),
    .bank_busy(bsy_o[0]), .irq(irq_o[0]));
  usb_out_bank_mgr #(.NUM_BANKS(1), .CNT_W(11)) u_usb_out_bank_mgr_single (
    .clk(clk), .rst_n(rst_n), .rx_valid(rv), .rx_count(rc), .ack(ack_o[1]), .nak(nak_o[1]),
    .sw_wr(wr), .sw_clr_rx(crx), .sw_clr_busy(cbz), .sw_ie_wr(iew), .sw_ie_val(iev),
    .rd_bank(rb), .rd_count(rdc[1]), .bank_sel(sel_o[1]), .rx_flag(flg_o[1]),
    .bank_busy(bsy_o[1]), .irq(irq_o[1]));

  logic [1:0]  m_busy [2];
  logic        m_wp [2], m_sp [2], m_flag [2], m_ie [2];
  logic [10:0] m_cnt [2][2];

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic f_take(int k, logic v);
    return v & ~m_busy[k][m_wp[k]];
  endfunction

  task automatic step(input logic v, input logic [10:0] c, input logic w, input logic cr,
                      input logic cb, input logic ew, input logic ev, input logic b);
    logic tk, rl;
    rv = v; rc = c; wr = w; crx = cr; cbz = cb; iew = ew; iev = ev; rb = b;
    #1;
    for (int k = 0; k < 2; k++) begin
      tk = f_take(k, v);
      chk(k == 0 ? "R7 ack" : "R6 ack", {15'd0, ack_o[k]}, {15'd0, tk});
      chk(k == 0 ? "R7 nak" : "R6 nak", {15'd0, nak_o[k]}, {15'd0, v & ~tk});
      chk("R8 count", {5'd0, rdc[k]}, {5'd0, m_cnt[k][b]});
    end
    @(posedge clk);
    for (int k = 0; k < 2; k++) begin
      tk = f_take(k, v);
      rl = w & cb & m_busy[k][m_sp[k]];
      if (tk) begin
        m_busy[k][m_wp[k]] = 1'b1;
        m_cnt[k][m_wp[k]] = c;
        if (k == 0) m_wp[k] = ~m_wp[k];
      end
      if (rl) begin
        m_busy[k][m_sp[k]] = 1'b0;
        if (k == 0) m_sp[k] = ~m_sp[k];
      end
      if (tk) m_flag[k] = 1'b1;
      else if (w && cr) m_flag[k] = 1'b0;
      if (ew) m_ie[k] = ev;
    end
    @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      chk("R5 bank_sel", {15'd0, sel_o[k]}, {15'd0, m_sp[k]});
      chk("R2 rx_flag", {15'd0, flg_o[k]}, {15'd0, m_flag[k]});
      chk("R2 bank_busy", {15'd0, bsy_o[k]}, {15'd0, m_busy[k][m_sp[k]]});
      chk("R3 irq", {15'd0, irq_o[k]}, {15'd0, m_flag[k] & m_ie[k]});
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0017));
    for (int k = 0; k < 2; k++) begin
      m_busy[k] = '0; m_wp[k] = 0; m_sp[k] = 0; m_flag[k] = 0; m_ie[k] = 0;
      m_cnt[k][0] = '0; m_cnt[k][1] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    for (int k = 0; k < 2; k++) begin
      chk("R1 rx_flag", {15'd0, flg_o[k]}, 16'd0);
      chk("R1 bank_busy", {15'd0, bsy_o[k]}, 16'd0);
      chk("R1 bank_sel", {15'd0, sel_o[k]}, 16'd0);
      chk("R1 irq", {15'd0, irq_o[k]}, 16'd0);
    end
    step(0, 0, 0, 0, 0, 1, 1, 0);
    step(1, 11'd5, 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0, 0);
    chk("R9 zero write flag", {15'd0, flg_o[1]}, 16'd1);
    chk("R9 zero write busy", {15'd0, bsy_o[1]}, 16'd1);
    step(0, 0, 1, 1, 0, 0, 0, 0);
    for (int k = 0; k < 2; k++) begin
      chk("R4 flag cleared", {15'd0, flg_o[k]}, 16'd0);
      chk("R4 busy kept", {15'd0, bsy_o[k]}, 16'd1);
      chk("R4 sel kept", {15'd0, sel_o[k]}, 16'd0);
    end
    step(1, 11'd64, 1, 1, 0, 0, 0, 1);
    chk("R10 set wins", {15'd0, flg_o[0]}, 16'd1);
    step(1, 11'd9, 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 1, 0, 0, 0);
    step(1, 11'd33, 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 1, 0, 0, 0);
    step(0, 0, 1, 0, 1, 0, 0, 0);
    step(0, 0, 1, 0, 1, 0, 0, 0);
    chk("R9 idle release", {15'd0, sel_o[0]}, {15'd0, m_sp[0]});
    for (int i = 0; i < 3000; i++) begin
      logic w;
      w = ($urandom % 3) == 0;
      step(($urandom % 3) == 0, 11'($urandom), w, w & $urandom % 2, w & $urandom % 2,
           ($urandom % 8) == 0, $urandom % 2, $urandom % 2);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule